// File: doc/BRIEF.md
# Banked Memory Map Decoder

This block sits on a 16-bit CPU address bus and decides, for every access, which memory or register target answers. Its outputs are a target code, the offset inside that target and, for banked targets, the bank number. The memories themselves and the cartridge bank controller live outside it. The decoder holds the work-RAM bank register. It also gates accesses: the sprite table is blocked during busy video modes, and the hole below the I/O page never responds. When no target answers, the decoder supplies the fill byte 0xFF.

Writes to the cartridge ROM window store nothing. They leave as control writes to the bank controller. A sticky flag records any write into the external RAM window, so a save can be flushed later. The flag lives in a two-state machine. The state DS_CLEAN moves to DS_DIRTY on the MARK transition, which is any write to 0xA000–0xBFFF. DS_DIRTY returns to DS_CLEAN on the WIPE transition, which is a clear request in a cycle with no such write. In every other case the state holds. The decode path is combinational. The bank register and the flag state are registered.

Top module: `mmap_decoder`

## Requirements
- R1: Addresses 0x0000–0x3FFF give target code 0 and 0x4000–0x7FFF give code 1. Both take the offset addr[13:0] and bank 0.
- R2: A write below 0x8000 raises `ctrl_wr` and never raises `tgt_wr`. `ctrl_wr` stays low for every other address.
- R3: 0x8000–0x9FFF gives code 2 with offset addr[12:0]. Its bank equals the `vram_bank` input.
- R4: In 0xA000–0xBFFF, `clk_sel` high gives code 4. Otherwise `xram_en` high gives code 3. Otherwise the code is 15. Codes 3 and 4 take offset addr[12:0].
- R5: 0xC000–0xCFFF and its echo 0xE000–0xEFFF give code 5 with bank 0. 0xD000–0xDFFF and its echo 0xF000–0xFDFF give code 6, whose bank equals the work-RAM bank register. All four take offset addr[11:0].
- R6: The work-RAM bank register resets to 1. A load keeps only bits [2:0] of `wbank_din`, and a loaded value of 0 is stored as 1.
- R7: 0xFE00–0xFE9F gives code 7 with offset addr[7:0] when `vid_mode` is 0 or 1. For modes 2 and 3 it gives code 15, so reads get the fill byte and writes are dropped.
- R8: 0xFEA0–0xFEFF always gives code 15. Writes there never raise `tgt_wr`.
- R9: 0xFF00–0xFF7F gives code 8 and 0xFF80–0xFFFE gives code 9, both with offset addr[6:0]. 0xFFFF gives code 10 with offset 0.
- R10: `xram_dirty` resets low. Any write to 0xA000–0xBFFF sets it on the next edge, whatever `clk_sel` and `xram_en` are. It stays set until `dirty_clr` is high in a cycle with no such write. A write in the same cycle as a clear wins.
- R11: With code 15, offset and bank are 0, `dflt_valid` is 1 and `dflt_data` is 0xFF. Otherwise `dflt_valid` is 0 and `dflt_data` is 0. `tgt_rd` follows `rd` when the code is not 15. `tgt_wr` follows `wr` for codes 2 to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 16 | Bus address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| vid_mode | input | 2 | Current video mode |
| clk_sel | input | 1 | Cartridge RAM window maps to clock registers |
| xram_en | input | 1 | External RAM access enabled |
| vram_bank | input | 1 | Selected video RAM bank |
| wbank_ld | input | 1 | Load the work-RAM bank register |
| wbank_din | input | 8 | Value for the work-RAM bank register |
| dirty_clr | input | 1 | Clear the external RAM dirty flag |
| tgt | output | 4 | Target code |
| ofs | output | 14 | Offset within target |
| bank | output | 3 | Bank within target |
| tgt_rd | output | 1 | Read issued to target |
| tgt_wr | output | 1 | Write issued to target |
| ctrl_wr | output | 1 | Control write to bank controller |
| dflt_valid | output | 1 | No target responds |
| dflt_data | output | 8 | Fill read data |
| wram_bank | output | 3 | Work-RAM bank register |
| xram_dirty | output | 1 | Sticky external RAM write flag |

## Verification
The full 64 Ki address space is swept once in a plain configuration: sprite access open, external RAM on, clock registers off. That sweep pins every region boundary and every offset width. The sprite page is swept again in both blocked video modes, to separate the gating from the plain range decode. The cartridge RAM window is swept with clock registers selected and then with everything off, which shows the priority between the two enables. All 256 bank-register loads, write sweeps and flag sequences then cover the zero-to-one remap, the control-write path and the write-over-clear ordering.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
    typedef enum logic [3:0] {
        TGT_ROM_FIX  = 4'd0,
        TGT_ROM_SW   = 4'd1,
        TGT_VRAM     = 4'd2,
        TGT_XRAM     = 4'd3,
        TGT_CLKREG   = 4'd4,
        TGT_WRAM_FIX = 4'd5,
        TGT_WRAM_SW  = 4'd6,
        TGT_SPRITE   = 4'd7,
        TGT_IO       = 4'd8,
        TGT_HRAM     = 4'd9,
        TGT_IE       = 4'd10,
        TGT_NONE     = 4'd15
    } tgt_e;

    typedef enum logic {
        DS_CLEAN = 1'b0,
        DS_DIRTY = 1'b1
    } dirty_st_e;

    localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/wram_bank_reg.sv
module wram_bank_reg #(
    parameter int WB_W  = 3,
    parameter int DIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [DIN_W-1:0] din,
    output logic [WB_W-1:0]  bank
);
    localparam logic [WB_W-1:0] BANK_ONE = WB_W'(1);

    logic [WB_W-1:0] low_bits;
    assign low_bits = din[WB_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank <= BANK_ONE;
        end else if (ld) begin
            bank <= (low_bits == '0) ? BANK_ONE : low_bits;
        end
    end

    AST_BANK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bank != '0); // R6
    AST_BANK_ZERO_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && low_bits == '0) |=> (bank == BANK_ONE)); // R6
endmodule

// File: rtl/region_decode.sv
module region_decode
    import mmap_pkg::*;
#(
    parameter int OFS_W  = 14,
    parameter int WB_W   = 3,
    parameter int VB_W   = 1,
    parameter int BANK_W = 3
) (
    input  logic [15:0]       addr,
    input  logic [1:0]        vid_mode,
    input  logic              clk_sel,
    input  logic              xram_en,
    input  logic [WB_W-1:0]   wram_bank,
    input  logic [VB_W-1:0]   vram_bank,
    output tgt_e              tgt,
    output logic [OFS_W-1:0]  ofs,
    output logic [BANK_W-1:0] bank
);
    always_comb begin
        tgt  = TGT_NONE;
        ofs  = '0;
        bank = '0;
        unique case (addr[15:12])
            4'h0, 4'h1, 4'h2, 4'h3: begin
                tgt = TGT_ROM_FIX;
                ofs = OFS_W'(addr[13:0]);
            end
            4'h4, 4'h5, 4'h6, 4'h7: begin
                tgt = TGT_ROM_SW;
                ofs = OFS_W'(addr[13:0]);
            end
            4'h8, 4'h9: begin
                tgt  = TGT_VRAM;
                ofs  = OFS_W'(addr[12:0]);
                bank = BANK_W'(vram_bank);
            end
            4'hA, 4'hB: begin
                if (clk_sel) begin
                    tgt = TGT_CLKREG;
                    ofs = OFS_W'(addr[12:0]);
                end else if (xram_en) begin
                    tgt = TGT_XRAM;
                    ofs = OFS_W'(addr[12:0]);
                end
            end
            4'hC, 4'hE: begin
                tgt = TGT_WRAM_FIX;
                ofs = OFS_W'(addr[11:0]);
            end
            4'hD: begin
                tgt  = TGT_WRAM_SW;
                ofs  = OFS_W'(addr[11:0]);
                bank = BANK_W'(wram_bank);
            end
            4'hF: begin
                if (addr < 16'hFE00) begin
                    tgt  = TGT_WRAM_SW;
                    ofs  = OFS_W'(addr[11:0]);
                    bank = BANK_W'(wram_bank);
                end else if (addr < 16'hFEA0) begin
                    if (!vid_mode[1]) begin
                        tgt = TGT_SPRITE;
                        ofs = OFS_W'(addr[7:0]);
                    end
                end else if (addr < 16'hFF00) begin
                    tgt = TGT_NONE;
                end else if (addr < 16'hFF80) begin
                    tgt = TGT_IO;
                    ofs = OFS_W'(addr[6:0]);
                end else if (addr != 16'hFFFF) begin
                    tgt = TGT_HRAM;
                    ofs = OFS_W'(addr[6:0]);
                end else begin
                    tgt = TGT_IE;
                end
            end
        endcase
    end
endmodule

// File: rtl/dirty_fsm.sv
module dirty_fsm
    import mmap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic dirty
);
    dirty_st_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_CLEAN: if (set_req)              state_d = DS_DIRTY; // MARK
            DS_DIRTY: if (clr_req && !set_req)  state_d = DS_CLEAN; // WIPE
        endcase
    end

    always_comb begin
        unique case (state_q)
            DS_CLEAN: dirty = 1'b0;
            DS_DIRTY: dirty = 1'b1;
        endcase
    end

    AST_DIRTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty && !clr_req) |=> dirty); // R10
    AST_DIRTY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> dirty); // R10
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
#(
    parameter int OFS_W = 14,
    parameter int WB_W  = 3,
    parameter int VB_W  = 1,
    parameter int DIN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       addr,
    input  logic              rd,
    input  logic              wr,
    input  logic [1:0]        vid_mode,
    input  logic              clk_sel,
    input  logic              xram_en,
    input  logic [VB_W-1:0]   vram_bank,
    input  logic              wbank_ld,
    input  logic [DIN_W-1:0]  wbank_din,
    input  logic              dirty_clr,
    output logic [3:0]        tgt,
    output logic [OFS_W-1:0]  ofs,
    output logic [2:0]        bank,
    output logic              tgt_rd,
    output logic              tgt_wr,
    output logic              ctrl_wr,
    output logic              dflt_valid,
    output logic [7:0]        dflt_data,
    output logic [WB_W-1:0]   wram_bank,
    output logic              xram_dirty
);
    localparam int BANK_W = 3;

    tgt_e              tgt_sel;
    logic [BANK_W-1:0] bank_sel;
    logic              is_rom, no_tgt, xram_win;

    wram_bank_reg #(.WB_W(WB_W), .DIN_W(DIN_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .ld(wbank_ld), .din(wbank_din), .bank(wram_bank)
    );

    region_decode #(.OFS_W(OFS_W), .WB_W(WB_W), .VB_W(VB_W), .BANK_W(BANK_W)) u_dec (
        .addr(addr), .vid_mode(vid_mode), .clk_sel(clk_sel), .xram_en(xram_en),
        .wram_bank(wram_bank), .vram_bank(vram_bank),
        .tgt(tgt_sel), .ofs(ofs), .bank(bank_sel)
    );

    assign xram_win = (addr[15:13] == 3'b101);

    dirty_fsm u_dirty (
        .clk(clk), .rst_n(rst_n), .set_req(wr && xram_win), .clr_req(dirty_clr),
        .dirty(xram_dirty)
    );

    assign is_rom     = !addr[15];
    assign no_tgt     = (tgt_sel == TGT_NONE);
    assign tgt        = tgt_sel;
    assign bank       = bank_sel;
    assign ctrl_wr    = wr && is_rom;
    assign tgt_wr     = wr && !is_rom && !no_tgt;
    assign tgt_rd     = rd && !no_tgt;
    assign dflt_valid = no_tgt;
    assign dflt_data  = no_tgt ? FILL_BYTE : 8'h00;

    AST_ROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr < 16'h8000) |-> (ctrl_wr && !tgt_wr)); // R2
    AST_SPRITE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= 16'hFE00 && addr < 16'hFEA0 && vid_mode[1]) |-> (dflt_valid && !tgt_wr && !tgt_rd)); // R7
    AST_HOLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= 16'hFEA0 && addr < 16'hFF00) |-> (dflt_valid && dflt_data == 8'hFF && !tgt_wr)); // R8
    AST_SW_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:12] == 4'hD) |-> (bank == BANK_W'(wram_bank))); // R5
endmodule

// File: tb/tb_mmap_decoder.sv
module tb_mmap_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [1:0]  vid_mode = 2'd0;
    logic        clk_sel = 1'b0, xram_en = 1'b1;
    logic [0:0]  vram_bank = 1'b1;
    logic        wbank_ld = 1'b0;
    logic [7:0]  wbank_din = '0;
    logic        dirty_clr = 1'b0;
    logic [3:0]  tgt;
    logic [13:0] ofs;
    logic [2:0]  bank;
    logic        tgt_rd, tgt_wr, ctrl_wr, dflt_valid, xram_dirty;
    logic [7:0]  dflt_data;
    logic [2:0]  wram_bank;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mmap_decoder dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .vid_mode(vid_mode),
        .clk_sel(clk_sel), .xram_en(xram_en), .vram_bank(vram_bank), .wbank_ld(wbank_ld),
        .wbank_din(wbank_din), .dirty_clr(dirty_clr), .tgt(tgt), .ofs(ofs), .bank(bank),
        .tgt_rd(tgt_rd), .tgt_wr(tgt_wr), .ctrl_wr(ctrl_wr), .dflt_valid(dflt_valid),
        .dflt_data(dflt_data), .wram_bank(wram_bank), .xram_dirty(xram_dirty)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
        end
    endtask

    // expected {code, offset, bank, dflt_valid, dflt_data, tgt_rd}
    function automatic logic [30:0] model(input int a, input int m, input bit cs, input bit xe,
                                          input int wb, input int vb, input bit r);
        int code = 15, o = 0, b = 0;
        if (a < 'h4000)       begin code = 0; o = a % 'h4000; end                 // R1
        else if (a < 'h8000)  begin code = 1; o = a % 'h4000; end                 // R1
        else if (a < 'hA000)  begin code = 2; o = a % 'h2000; b = vb; end         // R3
        else if (a < 'hC000)  begin                                                // R4
            if (cs)      begin code = 4; o = a % 'h2000; end
            else if (xe) begin code = 3; o = a % 'h2000; end
        end
        else if (a < 'hD000 || (a >= 'hE000 && a < 'hF000)) begin code = 5; o = a % 'h1000; end // R5
        else if (a < 'hFE00)  begin code = 6; o = a % 'h1000; b = wb; end         // R5
        else if (a < 'hFEA0)  begin if (m < 2) begin code = 7; o = a - 'hFE00; end end // R7
        else if (a < 'hFF00)  code = 15;                                           // R8
        else if (a < 'hFF80)  begin code = 8; o = a - 'hFF00; end                 // R9
        else if (a < 'hFFFF)  begin code = 9; o = a - 'hFF80; end                 // R9
        else                  code = 10;                                           // R9
        return {4'(code), 14'(o), 3'(b), code == 15, (code == 15) ? 8'hFF : 8'h00, r && code != 15}; // R11
    endfunction

    function automatic logic [30:0] actual();
        return {tgt, ofs, bank, dflt_valid, dflt_data, tgt_rd};
    endfunction

    task automatic load_bank(input logic [7:0] v);
        @(negedge clk); wbank_ld = 1'b1; wbank_din = v;
        @(negedge clk); wbank_ld = 1'b0;
    endtask

    task automatic wr_cycle(input logic [15:0] a, input bit clr);
        @(negedge clk); addr = a; wr = 1'b1; dirty_clr = clr;
        @(negedge clk); wr = 1'b0; dirty_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(wram_bank == 3'd1, "R6 reset bank", 32'(wram_bank), 32'd1);
        check(xram_dirty == 1'b0, "R10 reset flag", 32'(xram_dirty), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(wram_bank == 3'd1 && xram_dirty == 1'b0, "R6 R10 after reset release",
              {wram_bank, xram_dirty}, {3'd1, 1'b0});

        // R6: every load value
        for (int v = 0; v < 256; v++) begin
            logic [2:0] e;
            load_bank(8'(v));
            e = (v % 8 == 0) ? 3'd1 : 3'(v % 8);
            check(wram_bank == e, "R6 bank load", 32'(wram_bank), 32'(e));
        end

        load_bank(8'd5);
        rd = 1'b1;
        // full sweep, plain configuration: R1 R3 R4 R5 R7 R8 R9 R11
        for (int a = 0; a < 65536; a++) begin
            logic [30:0] e;
            @(negedge clk); addr = 16'(a);
            #2;
            e = model(a, 0, 1'b0, 1'b1, 5, 1, 1'b1);
            check(actual() == e, "R1/R3/R4/R5/R8/R9/R11 sweep", 32'(actual()), 32'(e));
        end

        // R7: blocked modes on sprite page
        for (int m = 2; m < 4; m++) begin
            vid_mode = 2'(m);
            for (int a = 'hFE00; a < 'hFF00; a++) begin
                logic [30:0] e;
                @(negedge clk); addr = 16'(a);
                #2;
                e = model(a, m, 1'b0, 1'b1, 5, 1, 1'b1);
                check(actual() == e, "R7 blocked mode", 32'(actual()), 32'(e));
            end
        end
        vid_mode = 2'd1;
        @(negedge clk); addr = 16'hFE10; #2;
        check(tgt == 4'd7 && ofs == 14'h10, "R7 mode 1 open", 32'(tgt), 32'd7);

        // R4: clock registers have priority, then everything off
        for (int c = 0; c < 2; c++) begin
            clk_sel = (c == 0);
            xram_en = (c == 0);
            for (int a = 'hA000; a < 'hC000; a += 'h11) begin
                logic [30:0] e;
                @(negedge clk); addr = 16'(a);
                #2;
                e = model(a, 1, clk_sel, xram_en, 5, 1, 1'b1);
                check(actual() == e, "R4 window select", 32'(actual()), 32'(e));
            end
        end
        clk_sel = 1'b0; xram_en = 1'b1;

        // R3: other video bank
        vram_bank = 1'b0;
        @(negedge clk); addr = 16'h9ABC; #2;
        check(bank == 3'd0 && ofs == 14'h1ABC, "R3 bank zero", {bank, ofs}, {3'd0, 14'h1ABC});

        // R2 / R11: write strobes
        rd = 1'b0;
        for (int a = 0; a < 65536; a += 'h0101) begin
            int code;
            bit ew;
            @(negedge clk); addr = 16'(a); wr = 1'b1;
            #2;
            code = 32'(model(a, 1, 1'b0, 1'b1, 5, 0, 1'b0) >> 27);
            ew = (code >= 2 && code <= 10);
            check(ctrl_wr == (a < 'h8000), "R2 control write", 32'(ctrl_wr), 32'(a < 'h8000));
            check(tgt_wr == ew && tgt_rd == 1'b0, "R11 target write", {tgt_wr, tgt_rd}, {ew, 1'b0});
        end
        @(negedge clk); wr = 1'b0; vid_mode = 2'd3; addr = 16'hFE20; wr = 1'b1; #2;
        check(tgt_wr == 1'b0, "R7 write dropped", 32'(tgt_wr), 32'd0);
        @(negedge clk); wr = 1'b0; vid_mode = 2'd0;

        // R10: dirty flag behaviour
        @(negedge clk); dirty_clr = 1'b1;
        @(negedge clk); dirty_clr = 1'b0;
        check(xram_dirty == 1'b0, "R10 cleared", 32'(xram_dirty), 32'd0);
        wr_cycle(16'hC123, 1'b0);
        check(xram_dirty == 1'b0, "R10 other write", 32'(xram_dirty), 32'd0);
        xram_en = 1'b0;
        wr_cycle(16'hB7FF, 1'b0);
        check(xram_dirty == 1'b1, "R10 set with ram off", 32'(xram_dirty), 32'd1);
        xram_en = 1'b1;
        repeat (5) @(negedge clk);
        check(xram_dirty == 1'b1, "R10 sticky", 32'(xram_dirty), 32'd1);
        wr_cycle(16'hA000, 1'b1);
        check(xram_dirty == 1'b1, "R10 write beats clear", 32'(xram_dirty), 32'd1);
        @(negedge clk); dirty_clr = 1'b1;
        @(negedge clk); dirty_clr = 1'b0;
        check(xram_dirty == 1'b0, "R10 wipe", 32'(xram_dirty), 32'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule